// File: doc/BRIEF.md
# SIMD Lane Swizzle Permute Unit

This block moves 32-bit words between the lanes of a vector wavefront. The source lane for each destination lane comes from a 16-bit swizzle pattern that the instruction supplies in two 8-bit offset fields. The pattern chooses one of two schemes. In the quad scheme, each lane picks any lane of its own aligned group of four. In the mask scheme, each lane computes its source index from its own index using an and mask, an or mask and an xor mask. This scheme never crosses a 32-lane half.

A per-lane execute mask decides which lanes are written. A lane that is switched off passes its current destination word through unchanged. An active lane that reads from a lane that is switched off receives zero. The permutation network is combinational and feeds a single output register. One instruction can be accepted on every cycle, and each result appears one clock after its start strobe.

Top module: `lane_swizzle_unit`

## Requirements
- R1: The pattern is {off_hi_i, off_lo_i}: off_hi_i supplies pattern bits 15:8 and off_lo_i supplies bits 7:0.
- R2: Pattern bit 15 = 1 selects quad mode. Pattern bit 15 = 0 selects mask mode.
- R3: In quad mode, lane L with group position q = L mod 4 reads lane (L - q) + sel_q. Here sel_0 = pattern[1:0], sel_1 = pattern[3:2], sel_2 = pattern[5:4] and sel_3 = pattern[7:6].
- R4: In mask mode, with and = pattern[4:0], or = pattern[9:5] and xor = pattern[14:10], the low five bits of the source index are (((L mod 32) & and) | or) ^ xor.
- R5: In mask mode, the source lane keeps the bits of L above bit 4, so data stays inside its 32-lane half.
- R6: A lane whose exec_i bit is 0 outputs its own dst_i word.
- R7: An active lane whose source lane has exec_i bit 0 outputs zero.
- R8: valid_o is 1 exactly one clock after start_i is 1 and 0 otherwise. start_i may be 1 on consecutive cycles, and each cycle yields its own result.
- R9: After reset, valid_o is 0 and result_o is 0. Without start_i, result_o holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Accepts the operands on this edge |
| off_lo_i | input | 8 | Pattern bits 7:0 |
| off_hi_i | input | 8 | Pattern bits 15:8 |
| exec_i | input | LANES | Per-lane execute mask |
| src_i | input | LANES*DW | Source vector, lane k at bits k*DW +: DW |
| dst_i | input | LANES*DW | Current destination vector |
| valid_o | output | 1 | Result valid, one clock after start_i |
| result_o | output | LANES*DW | Permuted destination vector |

## Verification
The only state is the output register and the valid flag, so any fault shows at the ports in the cycle after the start strobe that produced it. A wrong field decode or mode bit puts a wrong lane's word, a zero, or a stale destination word into particular lanes. Each lane is compared with a model derived from the requirements. A fault in the hold path or the strobe timing shows on the first idle cycle after a result or on back-to-back starts.

// File: rtl/lane_swizzle_unit.sv
module lane_swizzle_unit #(
  parameter int LANES = 64,
  parameter int DW    = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [7:0]          off_lo_i,
  input  logic [7:0]          off_hi_i,
  input  logic [LANES-1:0]    exec_i,
  input  logic [LANES*DW-1:0] src_i,
  input  logic [LANES*DW-1:0] dst_i,
  output logic                valid_o,
  output logic [LANES*DW-1:0] result_o
);
  localparam int HALF = 32;

  logic [15:0]         pat;
  logic                quad;
  logic [4:0]          m_and, m_or, m_xor;
  logic [LANES*DW-1:0] perm;

  assign pat   = {off_hi_i, off_lo_i};
  assign quad  = pat[15];
  assign m_and = pat[4:0];
  assign m_or  = pat[9:5];
  assign m_xor = pat[14:10];

  always_comb begin
    perm = '0;
    for (int i = 0; i < LANES; i++) begin
      int s;
      if (quad)
        s = (i & ~3) + int'(pat[2*(i%4) +: 2]);
      else
        s = (i & ~(HALF-1)) | int'(((5'(i) & m_and) | m_or) ^ m_xor);
      if (!exec_i[i])
        perm[i*DW +: DW] = dst_i[i*DW +: DW];
      else if (s < LANES && exec_i[s])
        perm[i*DW +: DW] = src_i[s*DW +: DW];
      else
        perm[i*DW +: DW] = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o  <= 1'b0;
      result_o <= '0;
    end else begin
      valid_o <= start_i;
      if (start_i) result_o <= perm;
    end
  end
endmodule

// File: rtl/lane_swizzle_chk.sv
module lane_swizzle_chk #(
  parameter int LANES = 64,
  parameter int DW    = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start_i,
  input logic [7:0]          off_lo_i,
  input logic [7:0]          off_hi_i,
  input logic [LANES-1:0]    exec_i,
  input logic [LANES*DW-1:0] src_i,
  input logic [LANES*DW-1:0] dst_i,
  input logic                valid_o,
  input logic [LANES*DW-1:0] result_o
);
  logic [4:0] lane0_mask_src;
  logic [1:0] lane0_quad_src;
  assign lane0_mask_src = {off_hi_i[1:0], off_lo_i[7:5]} ^ off_hi_i[6:2];
  assign lane0_quad_src = off_lo_i[1:0];

  AST_VALID_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> valid_o); // R8
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> !valid_o); // R8
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> $stable(result_o)); // R9
  AST_QUAD_LANE0: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && off_hi_i[7] && exec_i[0] && exec_i[lane0_quad_src]
    |=> result_o[DW-1:0] == $past(src_i[int'(lane0_quad_src)*DW +: DW])); // R3
  AST_MASK_LANE0: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !off_hi_i[7] && exec_i[0] && (int'(lane0_mask_src) < LANES) && exec_i[int'(lane0_mask_src)]
    |=> result_o[DW-1:0] == $past(src_i[int'(lane0_mask_src)*DW +: DW])); // R4
  AST_QUAD_INACTIVE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && off_hi_i[7] && exec_i[0] && !exec_i[lane0_quad_src]
    |=> result_o[DW-1:0] == '0); // R7

  for (genvar k = 0; k < LANES; k++) begin : g_keep
    AST_INACTIVE_KEEPS_DST: assert property (@(posedge clk) disable iff (!rst_n)
      start_i && !exec_i[k] |=> result_o[k*DW +: DW] == $past(dst_i[k*DW +: DW])); // R6
  end
endmodule

bind lane_swizzle_unit lane_swizzle_chk #(.LANES(LANES), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .off_lo_i(off_lo_i),
  .off_hi_i(off_hi_i), .exec_i(exec_i), .src_i(src_i), .dst_i(dst_i),
  .valid_o(valid_o), .result_o(result_o));

// File: tb/test_lane_swizzle_unit.sv
module test_lane_swizzle_unit;
  localparam int LANES = 64;
  localparam int DW    = 32;
  localparam int NV    = 8;
  // {off_hi, off_lo, exec}
  localparam logic [79:0] VEC [NV] = '{
    {8'h80, 8'h00, 64'hFFFF_FFFF_FFFF_FFFF},
    {8'h80, 8'h1B, 64'hFFFF_FFFF_FFFF_FFFF},
    {8'h80, 8'h4E, 64'h5555_5555_5555_5555},
    {8'h00, 8'h1F, 64'hFFFF_FFFF_FFFF_FFFF},
    {8'h04, 8'h1F, 64'hFFFF_0000_FFFF_F0F0},
    {8'h00, 8'hA0, 64'hFFFF_FFFF_FFFF_FFFF},
    {8'h7C, 8'h1F, 64'hAAAA_AAAA_0F0F_FFFF},
    {8'h80, 8'hE4, 64'hFFFF_FFFF_0000_0001}
  };

  logic clk = 0, rst_n = 0, start = 0;
  logic [7:0] off_lo = 0, off_hi = 0;
  logic [LANES-1:0] ex = '0;
  logic [LANES*DW-1:0] src, dst;
  logic valid;
  logic [LANES*DW-1:0] res;
  logic [DW-1:0] expv [LANES];
  string tagv [LANES];
  int checks = 0, fails = 0;

  lane_swizzle_unit #(.LANES(LANES), .DW(DW)) i_lane_swizzle_unit (
    .clk(clk), .rst_n(rst_n), .start_i(start), .off_lo_i(off_lo), .off_hi_i(off_hi),
    .exec_i(ex), .src_i(src), .dst_i(dst), .valid_o(valid), .result_o(res));

  always #4 clk = ~clk;

  function automatic logic [DW-1:0] model(int l, output string tag);
    logic [15:0] p = {off_hi, off_lo};
    int s;
    if (!ex[l]) begin tag = "R6"; return dst[l*DW +: DW]; end
    if (p[15]) begin
      int q = l % 4;
      s = l - q + int'(p[q*2 +: 2]);
      tag = "R2 R3";
    end else begin
      s = 32 * (l / 32) + int'(((5'(l % 32) & p[4:0]) | p[9:5]) ^ p[14:10]);
      tag = "R2 R4 R5";
    end
    if (!ex[s]) begin tag = "R7"; return '0; end
    return src[s*DW +: DW];
  endfunction

  task automatic prepare();
    for (int l = 0; l < LANES; l++) expv[l] = model(l, tagv[l]);
  endtask

  task automatic check_lanes(string extra);
    for (int l = 0; l < LANES; l++) begin
      checks++;
      if (res[l*DW +: DW] !== expv[l]) begin
        fails++;
        $display("FAIL %s %s lane %0d: got %h expected %h", tagv[l], extra, l, res[l*DW +: DW], expv[l]);
      end
    end
  endtask

  task automatic check_bit(string tag, logic act, logic exp_v);
    checks++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s: got %b expected %b", tag, act, exp_v);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(8 * 50000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < LANES; i++) begin
      src[i*DW +: DW] = 32'hA500_0000 + i * 32'h0001_0003;
      dst[i*DW +: DW] = 32'hD000_0000 | i;
    end
    repeat (3) @(negedge clk);
    check_bit("R9 reset valid", valid, 1'b0);
    checks++;
    if (res !== '0) begin fails++; $display("FAIL R9 reset result: got %h expected 0", res[DW-1:0]); end
    rst_n = 1;
    @(negedge clk);

    // table walk, back-to-back starts
    for (int v = 0; v < NV; v++) begin
      {off_hi, off_lo, ex} = VEC[v];
      start = 1;
      prepare();
      @(negedge clk);
      check_bit("R8 valid", valid, 1'b1);
      check_lanes("table");
    end

    // R9 hold and R8 valid drop
    start = 0;
    off_hi = 8'h80; off_lo = 8'hFF; ex = '1;
    @(negedge clk);
    check_bit("R8 no start", valid, 1'b0);
    for (int l = 0; l < LANES; l++) tagv[l] = "R9";
    check_lanes("hold");

    // R1: pattern bit 7 comes from off_lo, so this is mask mode with or=4
    off_hi = 8'h00; off_lo = 8'h80; ex = '1; start = 1;
    @(negedge clk);
    checks++;
    if (res[DW-1:0] !== src[4*DW +: DW]) begin
      fails++; $display("FAIL R1 lane 0: got %h expected %h", res[DW-1:0], src[4*DW +: DW]);
    end

    // R5: identity-free mask, upper half stays in upper half
    off_hi = 8'h00; off_lo = 8'h00; ex = '1; start = 1;
    @(negedge clk);
    checks++;
    if (res[40*DW +: DW] !== src[32*DW +: DW]) begin
      fails++; $display("FAIL R5 lane 40: got %h expected %h", res[40*DW +: DW], src[32*DW +: DW]);
    end

    // R7: quad broadcast of lane 1 which is inactive, R6 lane 1 keeps dst
    off_hi = 8'h80; off_lo = 8'h55; ex = ~64'h2; start = 1;
    @(negedge clk);
    checks++;
    if (res[0 +: DW] !== '0) begin
      fails++; $display("FAIL R7 lane 0: got %h expected 0", res[0 +: DW]);
    end
    checks++;
    if (res[DW +: DW] !== dst[DW +: DW]) begin
      fails++; $display("FAIL R6 lane 1: got %h expected %h", res[DW +: DW], dst[DW +: DW]);
    end
    start = 0;
    @(negedge clk);
    check_bit("R8 idle", valid, 1'b0);

    summary();
    $finish;
  end
endmodule